// File: doc/BRIEF.md
# Parallel Converter Start-and-Capture Sequencer

This block sits on the host side of a 16-bit sampling converter that has a parallel three-state data bus, an active-low read/convert strobe, an active-low select strobe and a BUSY flag. While its start-enable input is high, it launches conversions at a bounded rate. For each conversion it pulls read/convert low, waits out a setup interval, and only then pulls select low to open the conversion. It returns read/convert high shortly afterwards and leaves select low so that the word appears on the bus when the converter finishes.

BUSY is brought into the clock domain through a synchronizer. Once the rising edge of BUSY is seen there, the sequencer latches the bus into a holding register and emits it with a single-cycle valid strobe and a wrapping sample count. It raises select in that same cycle, well before the converter's automatic-restart window would close. If BUSY does not return within twice the nominal conversion time, the sequencer abandons the attempt, pulses a timeout flag and goes back to idle.

All intervals are given in nanoseconds as parameters and turned into clock cycles from a clock-frequency parameter, always rounding up. With the defaults (50 MHz clock) the figures are:

- setup: 5 cycles
- select-to-release: 2 cycles
- start spacing: 200 cycles
- timeout: 330 cycles

Top module: `pconv_seq_top`

## Requirements
- R1: While reset is applied, and after it is released with start-enable low, rc_n_o and cs_n_o are high, tvalid_o and tmo_o are low, and sample_cnt_o is zero.
- R2: cs_n_o falls only while rc_n_o is low, and rc_n_o has then been low for exactly SETUP_CYC (5) cycles, covering at least 100 ns.
- R3: rc_n_o returns high exactly STROBE_CYC (2) cycles after cs_n_o falls, which is within 200 ns. Neither strobe then changes until the capture or the timeout.
- R4: The word on data_i is registered on tdata_o, and tvalid_o is high for exactly one cycle, 3 clock edges after busy_i rises.
- R5: cs_n_o returns high in the same cycle that tvalid_o is high, which is 60 ns after BUSY rises and so within 250 ns. rc_n_o is high at that point.
- R6: Consecutive falls of rc_n_o are at least SPACE_CYC (200) cycles apart. A held start request launches exactly 200 cycles after the previous launch if the previous conversion has finished by then. Otherwise it launches one cycle after that conversion's tvalid_o.
- R7: With start_en_i low, no conversion is launched and rc_n_o stays high.
- R8: If BUSY has not risen TMO_CYC (330) cycles after rc_n_o rose, tmo_o pulses for one cycle and cs_n_o rises in that cycle. No tvalid_o is produced and sample_cnt_o is unchanged.
- R9: sample_cnt_o increments by one with each tvalid_o and wraps modulo 2^CNT_W.
- R10: tdata_o carries the two's-complement bus word bit for bit, including 16'h8000, 16'h7FFF, 16'hFFFF and 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_en_i | input | 1 | Request to run conversions while high |
| busy_i | input | 1 | Converter BUSY flag, asynchronous, low while converting |
| data_i | input | DATA_W | Converter parallel data bus |
| rc_n_o | output | 1 | Read/convert strobe, low selects convert |
| cs_n_o | output | 1 | Select strobe, active low |
| tdata_o | output | DATA_W | Captured conversion word |
| tvalid_o | output | 1 | One-cycle strobe marking a new word |
| sample_cnt_o | output | CNT_W | Count of words delivered, wrapping |
| tmo_o | output | 1 | One-cycle flag when BUSY failed to return |

## Verification
Each result has a fixed latency, and the bench checks it at that cycle:

- The select fall is due 5 cycles after the read/convert fall.
- The read/convert release is due 2 cycles after the select fall.
- The captured word, the valid strobe and the select release are all due 3 edges after BUSY rises, because of the two synchronizer flops and the capture register.
- A timeout is due 330 cycles after read/convert is released.

A monitor samples the pins on the falling clock edge and stamps every strobe edge, BUSY edge, valid and timeout with a cycle number. The directed tasks compare the differences between these stamps against the latencies above, so no result depends on process order at the active edge. The behavioural converter model raises BUSY between clock edges, after a conversion length chosen by each task. That length lets the spacing test cover both a launch held back by the 200-cycle minimum and a launch that follows directly after a slow conversion.

// File: rtl/pconv_pkg.sv
`timescale 1ns/1ps
package pconv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_WAIT   = 2'd3
  } seq_state_t;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
    longint c;
    c = (ns * clk_hz + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pconv_busy_rise.sv
`timescale 1ns/1ps
module pconv_busy_rise #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic rise_o
);
  // pipe[SYNC_N-1] is the synchronized level, pipe[SYNC_N] its delayed copy
  logic [SYNC_N:0] pipe_q;
  logic [SYNC_N:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[SYNC_N-1:0], busy_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];

endmodule

// File: rtl/pconv_pace.sv
`timescale 1ns/1ps
module pconv_pace #(
  parameter int SPACE_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic ready_o
);
  localparam int CW = $clog2(SPACE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (launch_i)          cnt_d = CW'(SPACE_CYC - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == '0);

  // Independent gap counter: cycles since the previous launch, saturating.
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap_q <= CW'(SPACE_CYC);
    else if (launch_i)                  gap_q <= '0;
    else if (gap_q != CW'(SPACE_CYC))   gap_q <= gap_q + 1'b1;
  end

  // R6
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (gap_q >= CW'(SPACE_CYC - 1)));

endmodule

// File: rtl/pconv_fsm.sv
`timescale 1ns/1ps
module pconv_fsm
  import pconv_pkg::*;
#(
  parameter int SETUP_CYC  = 5,
  parameter int STROBE_CYC = 2,
  parameter int TMO_CYC    = 330,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en_i,
  input  logic              ready_i,
  input  logic              rise_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              launch_o,
  output logic              rc_n_o,
  output logic              cs_n_o,
  output logic [DATA_W-1:0] tdata_o,
  output logic              tvalid_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tmo_o
);
  localparam int MAX_A  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int PH_MAX = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int RUN_W  = $clog2(SETUP_CYC + 1) + 1;

  seq_state_t        st_q, st_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              cap_en;
  logic              tmo_d;
  logic [DATA_W-1:0] tdata_q;
  logic              tvalid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tmo_q;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    launch_o = 1'b0;
    cap_en   = 1'b0;
    tmo_d    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        ph_d = '0;
        if (start_en_i && ready_i) begin
          st_d     = ST_SETUP;
          launch_o = 1'b1;
        end
      end
      ST_SETUP: begin
        if (ph_q == PH_W'(SETUP_CYC - 1)) begin
          st_d = ST_STROBE;
          ph_d = '0;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_STROBE: begin
        if (ph_q == PH_W'(STROBE_CYC - 1)) begin
          st_d = ST_WAIT;
          ph_d = '0;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (rise_i) begin
          st_d   = ST_IDLE;
          ph_d   = '0;
          cap_en = 1'b1;
        end else if (ph_q == PH_W'(TMO_CYC - 1)) begin
          st_d  = ST_IDLE;
          ph_d  = '0;
          tmo_d = 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= '0;
      tvalid_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      tvalid_q <= cap_en;
      tmo_q    <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdata_q <= '0;
      cnt_q   <= '0;
    end else if (cap_en) begin
      tdata_q <= data_i;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign rc_n_o   = !((st_q == ST_SETUP) || (st_q == ST_STROBE));
  assign cs_n_o   = !((st_q == ST_STROBE) || (st_q == ST_WAIT));
  assign tdata_o  = tdata_q;
  assign tvalid_o = tvalid_q;
  assign cnt_o    = cnt_q;
  assign tmo_o    = tmo_q;

  // Checker: cycles that read/convert has been low with select still high.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_q <= '0;
    else if (!rc_n_o && cs_n_o) begin
      if (run_q != RUN_W'(SETUP_CYC))   run_q <= run_q + 1'b1;
    end else                            run_q <= '0;
  end

  // R2
  cs_after_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (!rc_n_o && $past(!rc_n_o)));
  // R2
  setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (run_q >= RUN_W'(SETUP_CYC)));
  // R3
  rc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_n_o) |-> !cs_n_o);
  // R3
  strobe_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o) && $past(rc_n_o)) |-> rc_n_o);
  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid_o |=> !tvalid_o);
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid_o |-> (cs_n_o && rc_n_o));
  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (cs_n_o && !tvalid_o && $stable(cnt_o)));
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid_o |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/pconv_seq_top.sv
`timescale 1ns/1ps
module pconv_seq_top #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int SETUP_NS   = 100,
  parameter int RELEASE_NS = 40,
  parameter int SPACING_NS = 4000,
  parameter int CONV_NS    = 3300,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rc_n_o,
  output logic              cs_n_o,
  output logic [DATA_W-1:0] tdata_o,
  output logic              tvalid_o,
  output logic [CNT_W-1:0]  sample_cnt_o,
  output logic              tmo_o
);
  localparam int SETUP_CYC  = pconv_pkg::ns_to_cycles(CLK_HZ, SETUP_NS);
  localparam int STROBE_CYC = pconv_pkg::ns_to_cycles(CLK_HZ, RELEASE_NS);
  localparam int SPACE_CYC  = pconv_pkg::ns_to_cycles(CLK_HZ, SPACING_NS);
  localparam int TMO_CYC    = 2 * pconv_pkg::ns_to_cycles(CLK_HZ, CONV_NS);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic launch;
  logic ready;
  logic rise;

  pconv_busy_rise #(.SYNC_N(SYNC_N)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .busy_i (busy_i),
    .rise_o (rise)
  );

  pconv_pace #(.SPACE_CYC(SPACE_CYC)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .launch_i (launch),
    .ready_o  (ready)
  );

  pconv_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .TMO_CYC    (TMO_CYC),
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_en_i (start_en_i),
    .ready_i    (ready),
    .rise_i     (rise),
    .data_i     (data_i),
    .launch_o   (launch),
    .rc_n_o     (rc_n_o),
    .cs_n_o     (cs_n_o),
    .tdata_o    (tdata_o),
    .tvalid_o   (tvalid_o),
    .cnt_o      (sample_cnt_o),
    .tmo_o      (tmo_o)
  );

  // R7
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!start_en_i && rc_n_o) |=> rc_n_o);
  // R5
  rise_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rise && !cs_n_o && rc_n_o) |=> cs_n_o);

endmodule

// File: tb/test_pconv_seq_top.sv
`timescale 1ns/1ps
module test_pconv_seq_top;
  localparam int CLK_T   = 20;
  localparam int SETUP   = 5;
  localparam int STROBE  = 2;
  localparam int SPACE   = 200;
  localparam int TMO     = 330;
  localparam int CAPLAT  = 3;
  localparam int CW      = 3;

  logic        clk;
  logic        rst_n;
  logic        start_en;
  logic        busy;
  logic [15:0] data_bus;
  logic        rc_n, cs_n, tvalid, tmo;
  logic [15:0] tdata;
  logic [CW-1:0] scnt;

  pconv_seq_top #(.CNT_W(CW)) i_pconv_seq_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_en_i   (start_en),
    .busy_i       (busy),
    .data_i       (data_bus),
    .rc_n_o       (rc_n),
    .cs_n_o       (cs_n),
    .tdata_o      (tdata),
    .tvalid_o     (tvalid),
    .sample_cnt_o (scnt),
    .tmo_o        (tmo)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  // Behavioural converter model
  logic [15:0] stub_word;
  int          conv_cyc;
  bit          hang;
  assign data_bus = (!cs_n && rc_n && busy) ? stub_word : 16'h0000;

  always begin
    @(negedge cs_n);
    if (!rc_n) begin
      #1 busy = 1'b0;
      if (!hang) begin
        repeat (conv_cyc) @(posedge clk);
        #5 busy = 1'b1;
      end else begin
        @(posedge cs_n);
        #1 busy = 1'b1;
      end
    end
  end

  // Pin monitor sampled on the falling clock edge
  int cyc;
  always @(posedge clk) cyc <= cyc + 1;

  int n_launch, n_valid, n_tmo, bad_order, bad_static;
  int t_rc_fall, t_rc_fall_prev, t_cs_fall, t_rc_rise, t_cs_rise;
  int t_busy_rise, t_valid, t_tmo;
  logic [15:0] v_data;
  logic [CW-1:0] v_cnt;
  logic p_rc, p_cs, p_busy;

  always @(negedge clk) begin
    if (p_rc === 1'b1 && rc_n === 1'b0) begin
      t_rc_fall_prev = t_rc_fall; t_rc_fall = cyc; n_launch++;
    end
    if (p_cs === 1'b1 && cs_n === 1'b0) begin
      t_cs_fall = cyc;
      if (rc_n !== 1'b0) bad_order++;
    end
    if (p_rc === 1'b0 && rc_n === 1'b1) t_rc_rise = cyc;
    if (p_cs === 1'b0 && cs_n === 1'b1) t_cs_rise = cyc;
    if (cs_n === 1'b0 && p_cs === 1'b0 && p_rc === 1'b1 && rc_n === 1'b0) bad_static++;
    if (p_busy === 1'b0 && busy === 1'b1) t_busy_rise = cyc;
    if (tvalid === 1'b1) begin
      n_valid++; t_valid = cyc; v_data = tdata; v_cnt = scnt;
    end
    if (tmo === 1'b1) begin n_tmo++; t_tmo = cyc; end
    p_rc = rc_n; p_cs = cs_n; p_busy = busy;
  end

  int checks, fails;
  bit finished;
  int exp_cnt;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_launch(input int n0);
    for (int i = 0; i < 3000 && n_launch <= n0; i++) @(negedge clk);
  endtask

  task automatic wait_valid(input int n0);
    for (int i = 0; i < 3000 && n_valid <= n0; i++) @(negedge clk);
  endtask

  task automatic do_conv(input logic [15:0] word, input int cc);
    int nl, nv;
    nl = n_launch; nv = n_valid;
    stub_word = word; conv_cyc = cc; hang = 1'b0;
    @(negedge clk); start_en = 1'b1;
    wait_launch(nl);
    start_en = 1'b0;
    wait_valid(nv);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(rc_n === 1'b1 && cs_n === 1'b1, "R1 strobes in reset", {rc_n, cs_n}, 3);
    chk(tvalid === 1'b0 && tmo === 1'b0, "R1 flags in reset", {tvalid, tmo}, 0);
    chk(scnt === '0, "R1 count in reset", scnt, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rc_n === 1'b1 && cs_n === 1'b1 && tvalid === 1'b0, "R1 after release",
        {rc_n, cs_n, tvalid}, 6);
  endtask

  task automatic t_single(input logic [15:0] word, input int cc);
    int nv;
    nv = n_valid;
    do_conv(word, cc);
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk(t_cs_fall - t_rc_fall == SETUP, "R2 setup length", t_cs_fall - t_rc_fall, SETUP);
    chk(bad_order == 0, "R2 strobe order", bad_order, 0);
    chk(t_rc_rise - t_cs_fall == STROBE, "R3 release delay", t_rc_rise - t_cs_fall, STROBE);
    chk(bad_static == 0, "R3 static strobes", bad_static, 0);
    chk(t_valid - t_busy_rise == CAPLAT, "R4 capture latency", t_valid - t_busy_rise, CAPLAT);
    chk(v_data === word, "R10 data word", v_data, word);
    chk(t_cs_rise == t_valid, "R5 select release", t_cs_rise, t_valid);
    chk(v_cnt == CW'(exp_cnt), "R9 sample count", v_cnt, exp_cnt);
    repeat (5) @(negedge clk);
    chk(n_valid == nv + 1, "R4 single valid", n_valid, nv + 1);
  endtask

  task automatic t_idle;
    int nl;
    nl = n_launch;
    start_en = 1'b0;
    repeat (400) @(negedge clk);
    chk(n_launch == nl && rc_n === 1'b1, "R7 no launch when disabled", n_launch, nl);
  endtask

  task automatic t_pace;
    int nl, a, b, nv;
    stub_word = 16'h1234; conv_cyc = 150; hang = 1'b0;
    nl = n_launch;
    @(negedge clk); start_en = 1'b1;
    wait_launch(nl);
    a = t_rc_fall;
    wait_launch(nl + 1);
    conv_cyc = 260;
    chk(t_rc_fall - a == SPACE, "R6 held start spacing", t_rc_fall - a, SPACE);
    b = t_rc_fall;
    wait_launch(nl + 2);
    start_en = 1'b0;
    chk(t_rc_fall - t_valid == 1, "R6 launch after slow conversion", t_rc_fall - t_valid, 1);
    chk(t_rc_fall - b >= SPACE, "R6 minimum spacing", t_rc_fall - b, SPACE);
    nv = n_valid;
    wait_valid(nv);
    exp_cnt = (exp_cnt + 3) % (1 << CW);
    chk(v_cnt == CW'(exp_cnt), "R9 count after burst", v_cnt, exp_cnt);
  endtask

  task automatic t_timeout;
    int nl, nt, nv;
    logic [CW-1:0] c0;
    nl = n_launch; nt = n_tmo; nv = n_valid; c0 = scnt;
    hang = 1'b1; stub_word = 16'hDEAD;
    @(negedge clk); start_en = 1'b1;
    wait_launch(nl);
    start_en = 1'b0;
    for (int i = 0; i < 1000 && n_tmo <= nt; i++) @(negedge clk);
    chk(t_tmo - t_rc_rise == TMO, "R8 timeout cycle", t_tmo - t_rc_rise, TMO);
    chk(t_cs_rise == t_tmo, "R8 select released", t_cs_rise, t_tmo);
    repeat (10) @(negedge clk);
    hang = 1'b0;
    chk(n_tmo == nt + 1, "R8 single timeout pulse", n_tmo, nt + 1);
    chk(n_valid == nv, "R8 no valid", n_valid, nv);
    chk(scnt == c0, "R8 count unchanged", scnt, c0);
  endtask

  task automatic t_wrap;
    logic [15:0] w;
    for (int k = 0; k < 9; k++) begin
      case (k % 4)
        0: w = 16'h8000;
        1: w = 16'h7FFF;
        2: w = 16'hFFFF;
        default: w = 16'h0000;
      endcase
      if (k == 8) w = 16'hA5C3;
      t_single(w, 120 + 7 * k);
    end
  endtask

  initial begin
    checks = 0; fails = 0; finished = 1'b0; exp_cnt = 0;
    cyc = 0; n_launch = 0; n_valid = 0; n_tmo = 0; bad_order = 0; bad_static = 0;
    t_rc_fall = 0; t_rc_fall_prev = 0; t_cs_fall = 0; t_rc_rise = 0; t_cs_rise = 0;
    t_busy_rise = 0; t_valid = 0; t_tmo = 0;
    p_rc = 1'b1; p_cs = 1'b1; p_busy = 1'b1;
    busy = 1'b1; stub_word = 16'h0000; conv_cyc = 150; hang = 1'b0;
    t_reset;
    t_single(16'h4C1D, 150);
    t_idle;
    t_pace;
    t_timeout;
    t_single(16'h0F0F, 160);
    t_wrap;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule